// File: doc/BRIEF.md
# Enable-Qualified Serial Pattern Detector

This block watches a one-bit serial stream and raises a flag when the bits 1, 0, 1, 1 have arrived in that order. Each clock cycle presents one candidate bit. A qualifying enable decides whether that bit counts. When the enable is low the bit is ignored and the machine keeps whatever partial progress it had.

The detector is a Moore machine with five states. The flag is high only while the machine sits in its match state. Once a match is reported, the search begins afresh, so the bits of a completed match are never reused for a later one. If a bit breaks a partial match, the machine drops back to the longest part of the pattern that is still consistent with the recent valid bits. A typical use is to place it behind a deserializer or a strobe-qualified line and use the flag as a one-per-occurrence event.

Top module: `bit_pattern_detector`

## Requirements
- R1: The valid bits 1, 0, 1, 1 in arrival order raise `hit` to 1 after the rising clock edge that samples the fourth bit. `hit` stays 0 for every earlier bit.
- R2: `hit` is 1 only in the match state. It stays 1 across cycles with `sample_en` = 0 and returns to 0 after the next valid bit.
- R3: Detection does not overlap. After a match, the stream 0, 1, 1 gives no new match. The stream 1, 0, 1, 1 gives a new match, because a valid 1 taken in the match state counts as a fresh first bit.
- R4: A cycle with `sample_en` = 0 has no effect, whatever `sample_bit` carries. Partial progress is kept, and `hit` does not change on that cycle.
- R5: If a 0 arrives after 1, 0, 1, the machine keeps 1, 0 as its progress. The stream 1, 0, 1, 0, 1, 1 therefore reports a match on its sixth bit.
- R6: Repeated valid 1s keep the first pattern bit. The stream 1, 1, 1, 0, 1, 1 reports a match on its sixth bit.
- R7: A synchronous reset (`rst` = 1 at a rising edge) forces the idle state with `hit` = 0 and discards partial progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Qualifies `sample_bit` on this cycle |
| sample_bit | input | 1 | Serial data bit |
| hit | output | 1 | Registered match flag (1 in the match state) |

## Verification
The block has no tunable size, so the bench builds it exactly as written. Short directed streams of four to eight bits are enough to visit all five states and every transition out of them, including the drop-back transitions after a mismatch. The exit from the match state is exercised on both a 0 and a 1, so that overlapping detection would be exposed. The bench also interleaves idle-enable cycles carrying both bit values, so a detector that ignored the enable would be caught.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_P1    = 3'd1,
    ST_P10   = 3'd2,
    ST_P101  = 3'd3,
    ST_MATCH = 3'd4
  } pd_state_t;
endpackage

// File: rtl/pd_next_state.sv
module pd_next_state
  import pd_pkg::*;
(
  input  pd_state_t cur,
  input  logic      en,
  input  logic      bit_in,
  output pd_state_t nxt
);
  always_comb begin
    nxt = cur;
    if (en) begin
      case (cur)
        ST_IDLE:  nxt = bit_in ? ST_P1    : ST_IDLE;
        ST_P1:    nxt = bit_in ? ST_P1    : ST_P10;
        ST_P10:   nxt = bit_in ? ST_P101  : ST_IDLE;
        ST_P101:  nxt = bit_in ? ST_MATCH : ST_P10;
        ST_MATCH: nxt = bit_in ? ST_P1    : ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_state_reg.sv
module pd_state_reg
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  pd_state_t nxt,
  output pd_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  // R4: an unqualified cycle leaves the state untouched
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cur));

  // R7: reset lands in idle
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> cur == ST_IDLE);
endmodule

// File: rtl/pd_flag_reg.sv
module pd_flag_reg
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pd_state_t nxt,
  output logic      flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (nxt == ST_MATCH);
  end
endmodule

// File: rtl/bit_pattern_detector.sv
module bit_pattern_detector
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic sample_bit,
  output logic hit
);
  pd_state_t state_q;
  pd_state_t state_d;

  pd_next_state u_next (
    .cur    (state_q),
    .en     (sample_en),
    .bit_in (sample_bit),
    .nxt    (state_d)
  );

  pd_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .en  (sample_en),
    .nxt (state_d),
    .cur (state_q)
  );

  pd_flag_reg u_flag (
    .clk  (clk),
    .rst  (rst),
    .nxt  (state_d),
    .flag (hit)
  );

  // R2: flag register tracks the match state
  a_r2_flag_is_match: assert property (@(posedge clk) disable iff (rst)
    hit == (state_q == ST_MATCH));

  // R1: a new match only completes from 1,0,1 with a valid 1
  a_r1_rise_from_p101: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(state_q) == ST_P101) && $past(sample_en) && $past(sample_bit));

  // R3: a valid bit in the match state never yields another match at once
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MATCH) && sample_en |=> !hit);

  // R7: reset clears the flag
  a_r7_flag_cleared: assert property (@(posedge clk)
    rst |=> !hit);
endmodule

// File: tb/bit_pattern_detector_test.sv
module bit_pattern_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic sample_bit = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bit_pattern_detector uut (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .sample_bit (sample_bit),
    .hit        (hit)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: hit=%0b expected=%0b", req, hit, exp);
    end
  endtask

  task automatic step(input logic e, input logic b, input logic exp, input string req);
    @(negedge clk);
    sample_en  = e;
    sample_bit = b;
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sample_en = 1'b0;
    @(posedge clk);
    #1;
    check(1'b0, "R7");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_basic();   // R1, R2
    do_reset();
    step(1, 1, 0, "R1"); step(1, 0, 0, "R1");
    step(1, 1, 0, "R1"); step(1, 1, 1, "R1");
    step(1, 0, 0, "R2");
  endtask

  task automatic t_hold_match();   // R2
    do_reset();
    step(1, 1, 0, "R2"); step(1, 0, 0, "R2");
    step(1, 1, 0, "R2"); step(1, 1, 1, "R2");
    step(0, 0, 1, "R2"); step(0, 1, 1, "R2"); step(0, 0, 1, "R2");
    step(1, 1, 0, "R2");
  endtask

  task automatic t_enable_gaps();   // R4
    do_reset();
    step(1, 1, 0, "R4"); step(0, 0, 0, "R4"); step(0, 1, 0, "R4");
    step(1, 0, 0, "R4"); step(0, 0, 0, "R4"); step(0, 1, 0, "R4");
    step(1, 1, 0, "R4"); step(0, 0, 0, "R4");
    step(1, 1, 1, "R4");
  endtask

  task automatic t_no_overlap();   // R3
    do_reset();
    step(1, 1, 0, "R3"); step(1, 0, 0, "R3"); step(1, 1, 0, "R3"); step(1, 1, 1, "R3");
    step(1, 0, 0, "R3"); step(1, 1, 0, "R3"); step(1, 1, 0, "R3");
    do_reset();
    step(1, 1, 0, "R3"); step(1, 0, 0, "R3"); step(1, 1, 0, "R3"); step(1, 1, 1, "R3");
    step(1, 1, 0, "R3"); step(1, 0, 0, "R3"); step(1, 1, 0, "R3"); step(1, 1, 1, "R3");
  endtask

  task automatic t_fallback();   // R5
    do_reset();
    step(1, 1, 0, "R5"); step(1, 0, 0, "R5"); step(1, 1, 0, "R5");
    step(1, 0, 0, "R5"); step(1, 1, 0, "R5"); step(1, 1, 1, "R5");
  endtask

  task automatic t_ones();   // R6
    do_reset();
    step(1, 1, 0, "R6"); step(1, 1, 0, "R6"); step(1, 1, 0, "R6");
    step(1, 0, 0, "R6"); step(1, 1, 0, "R6"); step(1, 1, 1, "R6");
  endtask

  task automatic t_reset_mid();   // R7
    do_reset();
    step(1, 1, 0, "R7"); step(1, 0, 0, "R7"); step(1, 1, 0, "R7");
    do_reset();
    step(1, 1, 0, "R7"); step(1, 0, 0, "R7"); step(1, 1, 0, "R7"); step(1, 1, 1, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_basic();
    t_hold_match();
    t_enable_gaps();
    t_no_overlap();
    t_fallback();
    t_ones();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule